// File: doc/BRIEF.md
# Line-Next-Event Multichannel Scaler Core

The block counts pulses on a parameterised set of input channels (32 by default) and reports them as a stream of 32-bit words. Each channel has its own counter. A channel-advance event (a "next line" event) snapshots every counter. Then, in ascending channel order, it emits one word for each channel that is not masked off. The words leave on a valid/ready interface toward a downstream FIFO. In multichannel mode the counters restart from zero at each advance. In accumulate mode they keep running, so each snapshot is a running total.

Three sources can drive the advance:
- **Internal:** a reference tick derived from the core clock, divided by a programmable prescaler.
- **External:** rising edges on an external strobe, divided by the same prescaler.
- **Software:** a write to a step key.

The prescaler holds one less than the number of source events per advance. An acquisition preset stops the run after a programmed number of advances. Acquisition starts in one of two ways. The run key starts counting at once. The arm key waits for the first external strobe edge before counting starts.

The block is configured through a simple word-addressed register port with combinational read data. The FIFO storage, bus adaptation and DMA sit outside it.

Top module: `mcs_scaler_core`

## Requirements
- R1: Register map (4-bit word address): 0 mode, 1 prescale, 2 copy-off mask, 3 acquisition preset, 4 advance count (read only), 5 status (read only: bit0 running, bit1 armed, bit2 done). Write-only keys, whose data is ignored: 8 run, 9 arm, 10 halt, 11 zero counters, 12 step. After reset all registers read 0 and out_valid is low.
- R2: While running, each cycle with pulse_in[i] high adds one to counter i. While not running, pulses are not counted.
- R3: Channel selection and order. On an advance, the snapshot value of each channel whose copy-off bit is 0 is emitted in ascending channel order. out_chan gives the channel index. out_last marks the final word of the advance.
- R4: Mode bit0 selects the counter behaviour. With bit0 = 0 the counters restart at each advance. With bit0 = 1 they keep accumulating across advances.
- R5: With mode bits[7:4] = 1 (internal source), an advance occurs every (P+1)*REF_DIV clock cycles while running, where P is the prescale value.
- R6: With mode bits[7:4] = 2 (external source), one advance occurs for every P+1 rising edges on ext_adv while running.
- R7: The step key produces an advance only when mode bits[7:4] = 0 and the block is running. Otherwise it is ignored.
- R8: Advance count and preset.
  - Each advance increments the advance count.
  - The run and arm keys reset the count to 0.
  - When a nonzero preset is reached, running stops and done is set, after which no further words are produced.
  - A preset of 0 means no limit.
- R9: The arm key sets the armed state. The first ext_adv rising edge then starts the run; that edge is not counted toward an advance.
- R10: The halt key stops acquisition at once and the counters hold their values. Only the zero key clears the counters.
- R11: While out_valid is high and out_ready is low, out_valid, out_data, out_chan and out_last stay unchanged.
- R12: An advance that arrives while a frame is still being emitted is held and taken after the frame's last word. Further advances in that interval merge into the held one.
- R13: With mode bit1 set, channel 0 counts one per running clock cycle and ignores pulse_in[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pulse_in | input | NUM_CH | One count per cycle high, per channel |
| ext_adv | input | 1 | External advance / arm strobe (rising edge) |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts word |
| out_data | output | CNT_W | Snapshot counter value |
| out_chan | output | $clog2(NUM_CH) | Channel index of out_data |
| out_last | output | 1 | Last word of this advance |

## Verification
On every cycle, the assertions check four things:
- the output holds steady under backpressure;
- channel indices rise strictly within a frame;
- no word follows a frame end in the next cycle, so held advances wait their turn;
- halt leaves the block idle, the advance count is frozen while idle, and done coincides with the count equal to the preset.

Only the directed scenarios can show the rest:
- the counted values themselves;
- the internal advance period;
- external prescaling and the uncounted arming edge;
- that the step key is ignored with a hardware source;
- that halted counters hold;
- that masked channels vanish from the stream.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 4;

    // register and key addresses
    localparam logic [ADDR_W-1:0] A_MODE     = 4'd0;
    localparam logic [ADDR_W-1:0] A_PRESCALE = 4'd1;
    localparam logic [ADDR_W-1:0] A_COPYOFF  = 4'd2;
    localparam logic [ADDR_W-1:0] A_PRESET   = 4'd3;
    localparam logic [ADDR_W-1:0] A_COUNT    = 4'd4;
    localparam logic [ADDR_W-1:0] A_STATUS   = 4'd5;
    localparam logic [ADDR_W-1:0] K_RUN      = 4'd8;
    localparam logic [ADDR_W-1:0] K_ARM      = 4'd9;
    localparam logic [ADDR_W-1:0] K_HALT     = 4'd10;
    localparam logic [ADDR_W-1:0] K_ZERO     = 4'd11;
    localparam logic [ADDR_W-1:0] K_STEP     = 4'd12;

    // advance source codes, mode bits [7:4]
    localparam logic [3:0] SRC_SOFT = 4'd0;
    localparam logic [3:0] SRC_INT  = 4'd1;
    localparam logic [3:0] SRC_EXT  = 4'd2;

    typedef struct packed {
        logic [3:0] src;
        logic       ref_ch0;
        logic       accumulate;
    } mode_t;

    typedef struct packed {
        logic run;
        logic arm;
        logic halt;
        logic zero;
        logic step;
    } keys_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } run_state_e;

    function automatic logic [REG_W-1:0] pack_mode(input mode_t m);
        return REG_W'({m.src, 2'b00, m.ref_ch0, m.accumulate});
    endfunction

endpackage

// File: rtl/mcs_regs.sv
module mcs_regs
    import mcs_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic [REG_W-1:0]      acq_cnt,
    input  logic [2:0]            status,
    output mode_t                 mode,
    output logic [REG_W-1:0]      prescale,
    output logic [NUM_CH-1:0]     copy_off,
    output logic [REG_W-1:0]      preset,
    output keys_t                 keys
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= '0;
            prescale <= '0;
            copy_off <= '0;
            preset   <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_MODE: begin
                    mode.src        <= reg_wdata[7:4];
                    mode.ref_ch0    <= reg_wdata[1];
                    mode.accumulate <= reg_wdata[0];
                end
                A_PRESCALE: prescale <= reg_wdata;
                A_COPYOFF:  copy_off <= reg_wdata[NUM_CH-1:0];
                A_PRESET:   preset   <= reg_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        keys.run  = reg_wr && (reg_addr == K_RUN);
        keys.arm  = reg_wr && (reg_addr == K_ARM);
        keys.halt = reg_wr && (reg_addr == K_HALT);
        keys.zero = reg_wr && (reg_addr == K_ZERO);
        keys.step = reg_wr && (reg_addr == K_STEP);
    end

    always_comb begin
        case (reg_addr)
            A_MODE:     reg_rdata = pack_mode(mode);
            A_PRESCALE: reg_rdata = prescale;
            A_COPYOFF:  reg_rdata = REG_W'(copy_off);
            A_PRESET:   reg_rdata = preset;
            A_COUNT:    reg_rdata = acq_cnt;
            A_STATUS:   reg_rdata = REG_W'(status);
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mcs_advance.sv
module mcs_advance
    import mcs_pkg::*;
#(
    parameter int REF_DIV = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       src,
    input  logic [REG_W-1:0] prescale,
    input  logic             running,
    input  logic             restart,
    input  logic             step_key,
    input  logic             ext_adv,
    output logic             ext_edge,
    output logic             adv
);

    localparam int REF_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
    localparam logic [REF_W-1:0] REF_TOP = REF_W'(REF_DIV - 1);

    logic             ext_q;
    logic [REF_W-1:0] ref_cnt;
    logic [REG_W-1:0] div_cnt;
    logic             ref_tick;
    logic             src_evt;
    logic             div_hit;

    always_ff @(posedge clk) begin
        if (rst) ext_q <= 1'b0;
        else     ext_q <= ext_adv;
    end

    assign ext_edge = ext_adv & ~ext_q;
    assign ref_tick = running && (src == SRC_INT) && (ref_cnt == REF_TOP);

    always_comb begin
        case (src)
            SRC_INT: src_evt = ref_tick;
            SRC_EXT: src_evt = running && ext_edge;
            default: src_evt = 1'b0;
        endcase
    end

    assign div_hit = src_evt && (div_cnt == prescale);
    assign adv     = div_hit || (running && step_key && (src == SRC_SOFT));

    always_ff @(posedge clk) begin
        if (rst || restart || !running) begin
            ref_cnt <= '0;
            div_cnt <= '0;
        end else begin
            ref_cnt <= (ref_cnt == REF_TOP) ? '0 : ref_cnt + 1'b1;
            if (src_evt)
                div_cnt <= div_hit ? '0 : div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mcs_counter_bank.sv
module mcs_counter_bank #(
    parameter int NUM_CH = 32,
    parameter int CNT_W  = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           count_en,
    input  logic [NUM_CH-1:0]              pulse_in,
    input  logic                           ref_ch0,
    input  logic                           take,
    input  logic                           accumulate,
    input  logic                           zero,
    output logic [NUM_CH-1:0][CNT_W-1:0]   counts
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic             inc;
        logic [CNT_W-1:0] cnt;

        if (ch == 0) begin : g_ref
            assign inc = count_en & (ref_ch0 | pulse_in[ch]);
        end else begin : g_plain
            assign inc = count_en & pulse_in[ch];
        end

        always_ff @(posedge clk) begin
            if (rst || zero)
                cnt <= '0;
            else if (take && !accumulate)
                cnt <= CNT_W'(inc);
            else
                cnt <= cnt + CNT_W'(inc);
        end

        assign counts[ch] = cnt;
    end

endmodule

// File: rtl/mcs_emitter.sv
module mcs_emitter #(
    parameter int NUM_CH = 32,
    parameter int CNT_W  = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           load,
    input  logic [NUM_CH-1:0][CNT_W-1:0]   counts,
    input  logic [NUM_CH-1:0]              copy_off,
    input  logic                           out_ready,
    output logic                           out_valid,
    output logic [CNT_W-1:0]               out_data,
    output logic [$clog2(NUM_CH)-1:0]      out_chan,
    output logic                           out_last,
    output logic                           busy
);

    localparam int CH_W = $clog2(NUM_CH);

    logic [NUM_CH-1:0][CNT_W-1:0] shadow;
    logic [NUM_CH-1:0]            keep;
    logic [CH_W-1:0]              idx;
    logic                         first_found, next_found;
    logic [CH_W-1:0]              first_idx, next_idx;

    // lowest enabled channel at load time
    always_comb begin
        first_found = 1'b0;
        first_idx   = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (!copy_off[c]) begin
                first_found = 1'b1;
                first_idx   = CH_W'(c);
            end
        end
    end

    // next kept channel above the current one
    always_comb begin
        next_found = 1'b0;
        next_idx   = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (keep[c] && (c > int'(idx))) begin
                next_found = 1'b1;
                next_idx   = CH_W'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
            keep <= '0;
        end else if (load) begin
            shadow <= counts;
            keep   <= ~copy_off;
            busy   <= first_found;
            idx    <= first_idx;
        end else if (busy && out_ready) begin
            if (next_found) idx  <= next_idx;
            else            busy <= 1'b0;
        end
    end

    assign out_valid = busy;
    assign out_data  = shadow[idx];
    assign out_chan  = idx;
    assign out_last  = busy && !next_found;

endmodule

// File: rtl/mcs_scaler_core.sv
module mcs_scaler_core
    import mcs_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int CNT_W   = 32,
    parameter int REF_DIV = 10
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_wr,
    input  logic [3:0]                  reg_addr,
    input  logic [31:0]                 reg_wdata,
    output logic [31:0]                 reg_rdata,
    input  logic [NUM_CH-1:0]           pulse_in,
    input  logic                        ext_adv,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [CNT_W-1:0]            out_data,
    output logic [$clog2(NUM_CH)-1:0]   out_chan,
    output logic                        out_last
);

    mode_t                        mode;
    keys_t                        keys;
    logic [REG_W-1:0]             prescale, preset, acq_q;
    logic [NUM_CH-1:0]            copy_off;
    logic [NUM_CH-1:0][CNT_W-1:0] counts;
    run_state_e                   st;
    logic                         done_q, pending_q;
    logic                         adv, ext_edge, busy, take;
    logic                         is_run, is_armed;

    assign is_run   = (st == ST_RUN);
    assign is_armed = (st == ST_ARMED);

    mcs_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .acq_cnt(acq_q), .status({done_q, is_armed, is_run}),
        .mode(mode), .prescale(prescale), .copy_off(copy_off),
        .preset(preset), .keys(keys)
    );

    mcs_advance #(.REF_DIV(REF_DIV)) u_adv (
        .clk(clk), .rst(rst),
        .src(mode.src), .prescale(prescale),
        .running(is_run), .restart(keys.run | keys.arm),
        .step_key(keys.step), .ext_adv(ext_adv),
        .ext_edge(ext_edge), .adv(adv)
    );

    // an advance (new or held) is taken only when the emitter is free
    assign take = (adv || pending_q) && !busy && is_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            done_q    <= 1'b0;
            acq_q     <= '0;
            pending_q <= 1'b0;
        end else if (keys.halt) begin
            st        <= ST_IDLE;
            pending_q <= 1'b0;
        end else if (keys.run || keys.arm) begin
            st        <= keys.run ? ST_RUN : ST_ARMED;
            done_q    <= 1'b0;
            acq_q     <= '0;
            pending_q <= 1'b0;
        end else begin
            if (is_armed && ext_edge)
                st <= ST_RUN;
            if (take) begin
                acq_q     <= acq_q + 1'b1;
                pending_q <= 1'b0;
                if ((preset != '0) && ((acq_q + 1'b1) == preset)) begin
                    st     <= ST_IDLE;
                    done_q <= 1'b1;
                end
            end else if (adv) begin
                pending_q <= 1'b1;
            end
        end
    end

    mcs_counter_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst),
        .count_en(is_run), .pulse_in(pulse_in), .ref_ch0(mode.ref_ch0),
        .take(take), .accumulate(mode.accumulate), .zero(keys.zero),
        .counts(counts)
    );

    mcs_emitter #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_emit (
        .clk(clk), .rst(rst),
        .load(take), .counts(counts), .copy_off(copy_off),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .out_chan(out_chan), .out_last(out_last), .busy(busy)
    );

endmodule

// File: rtl/mcs_scaler_core_chk.sv
module mcs_scaler_core_chk
    import mcs_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int CNT_W  = 32
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      out_valid,
    input logic                      out_ready,
    input logic [CNT_W-1:0]          out_data,
    input logic [$clog2(NUM_CH)-1:0] out_chan,
    input logic                      out_last,
    input logic                      is_run,
    input logic                      is_armed,
    input logic                      done,
    input logic [REG_W-1:0]          acq_cnt,
    input logic [REG_W-1:0]          preset,
    input logic                      reg_wr,
    input logic [ADDR_W-1:0]         reg_addr
);

    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_chan) && $stable(out_last));

    assert_ascending_chan_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !out_last |=> out_valid && (out_chan > $past(out_chan)));

    assert_frame_gap_R12: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_last |=> !out_valid);

    assert_done_at_preset_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (acq_cnt == preset) && !is_run);

    assert_halt_idle_R10: assert property (@(posedge clk) disable iff (rst)
        reg_wr && (reg_addr == K_HALT) |=> !is_run && !is_armed);

    assert_idle_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        !is_run && !(reg_wr && ((reg_addr == K_RUN) || (reg_addr == K_ARM)))
        |=> $stable(acq_cnt));

endmodule

bind mcs_scaler_core mcs_scaler_core_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_chan(out_chan), .out_last(out_last),
    .is_run(is_run), .is_armed(is_armed), .done(done_q),
    .acq_cnt(acq_q), .preset(preset),
    .reg_wr(reg_wr), .reg_addr(reg_addr)
);

// File: tb/mcs_scaler_core_tb.sv
module mcs_scaler_core_tb;

    localparam int NCH  = 32;
    localparam int REFD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [NCH-1:0] pulse_in = '0;
    logic        ext_adv = 1'b0;
    logic        out_valid, out_ready = 1'b1, out_last;
    logic [31:0] out_data;
    logic [4:0]  out_chan;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    logic [31:0] wd [0:15];
    logic [31:0] wc [0:15];
    logic        wl [0:15];
    int          ws [0:15];

    mcs_scaler_core #(.NUM_CH(NCH), .CNT_W(32), .REF_DIV(REFD)) u_dut (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .pulse_in(pulse_in), .ext_adv(ext_adv),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_chan(out_chan), .out_last(out_last)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic pulse(input logic [NCH-1:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            pulse_in = m;
            @(negedge clk);
            pulse_in = '0;
        end
    endtask

    task automatic ext_pulse();
        @(negedge clk);
        ext_adv = 1'b1;
        @(negedge clk);
        ext_adv = 1'b0;
    endtask

    task automatic collect(input string req, input int n);
        int got = 0;
        int guard = 0;
        while (got < n && guard < 500) begin
            if (out_valid && out_ready) begin
                wd[got] = out_data; wc[got] = 32'(out_chan);
                wl[got] = out_last; ws[got] = cyc;
                got++;
            end
            @(negedge clk);
            guard++;
        end
        chk(req, "words received", got, n);
    endtask

    task automatic quiet(input string req, input int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            if (out_valid) seen++;
            @(negedge clk);
        end
        chk(req, "cycles with out_valid", seen, 0);
    endtask

    task automatic fresh(input logic [31:0] mode, input logic [31:0] off);
        wr(4'd10, 0);
        wr(4'd0, mode);
        wr(4'd2, off);
        wr(4'd3, 0);
        wr(4'd11, 0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 6; a++) begin
            rd(4'(a), v);
            chk("R1", "register after reset", v, 0);
        end
        chk("R1", "out_valid after reset", 32'(out_valid), 0);
    endtask

    task automatic t_mask_order();
        fresh(32'h0, ~32'h0000_000A);
        pulse(32'h2, 3);                 // not running: ignored (R2)
        wr(4'd8, 0);
        pulse(32'h2, 2);
        pulse(32'h8, 4);
        pulse(32'h1, 1);                 // masked channel
        wr(4'd12, 0);
        collect("R3", 2);
        chk("R3", "first chan", wc[0], 1);
        chk("R2", "ch1 count", wd[0], 2);
        chk("R3", "first not last", 32'(wl[0]), 0);
        chk("R3", "second chan", wc[1], 3);
        chk("R3", "ch3 count", wd[1], 4);
        chk("R3", "second last", 32'(wl[1]), 1);
        quiet("R3", 3);
        wr(4'd12, 0);
        collect("R4", 2);
        chk("R4", "clearing ch1", wd[0], 0);
        chk("R4", "clearing ch3", wd[1], 0);
    endtask

    task automatic t_accumulate();
        fresh(32'h1, ~32'h4);
        wr(4'd8, 0);
        pulse(32'h4, 3);
        wr(4'd12, 0);
        collect("R4", 1);
        chk("R4", "accum first", wd[0], 3);
        pulse(32'h4, 2);
        wr(4'd12, 0);
        collect("R4", 1);
        chk("R4", "accum running total", wd[0], 5);
    endtask

    task automatic t_internal();
        fresh(32'h12, ~32'h1);
        wr(4'd1, 1);
        wr(4'd8, 0);
        collect("R5", 1);
        ws[1] = ws[0];
        collect("R5", 1);
        chk("R5", "advance period", 32'(ws[0] - ws[1]), 2 * REFD);
        chk("R13", "reference count per period", wd[0], 2 * REFD);
    endtask

    task automatic t_step_ignored();
        logic [31:0] v;
        fresh(32'h10, ~32'h1);
        wr(4'd1, 1000);
        wr(4'd8, 0);
        wr(4'd12, 0);
        quiet("R7", 30);
        rd(4'd4, v);
        chk("R7", "count after ignored step", v, 0);
    endtask

    task automatic t_external();
        logic [31:0] v;
        fresh(32'h20, ~32'h2);
        wr(4'd1, 2);
        wr(4'd9, 0);
        rd(4'd5, v);
        chk("R9", "status armed", v, 2);
        pulse(32'h2, 2);
        ext_pulse();
        rd(4'd5, v);
        chk("R9", "status running after edge", v, 1);
        pulse(32'h2, 5);
        ext_pulse();
        ext_pulse();
        @(negedge clk);
        chk("R6", "no advance after two edges", 32'(out_valid), 0);
        ext_pulse();
        collect("R6", 1);
        chk("R6", "ch1 count at third edge", wd[0], 5);
    endtask

    task automatic t_preset();
        logic [31:0] v;
        fresh(32'h0, ~32'h1);
        wr(4'd3, 2);
        wr(4'd8, 0);
        wr(4'd12, 0);
        collect("R8", 1);
        wr(4'd12, 0);
        collect("R8", 1);
        rd(4'd5, v);
        chk("R8", "status done", v, 4);
        rd(4'd4, v);
        chk("R8", "advance count", v, 2);
        wr(4'd12, 0);
        quiet("R8", 5);
        rd(4'd4, v);
        chk("R8", "count after done", v, 2);
    endtask

    task automatic t_halt_clear();
        logic [31:0] v;
        fresh(32'h0, ~32'h4);
        wr(4'd8, 0);
        pulse(32'h4, 3);
        wr(4'd10, 0);
        rd(4'd5, v);
        chk("R10", "status after halt", v, 0);
        pulse(32'h4, 2);
        wr(4'd8, 0);
        wr(4'd12, 0);
        collect("R10", 1);
        chk("R10", "held count", wd[0], 3);
        pulse(32'h4, 4);
        wr(4'd10, 0);
        wr(4'd11, 0);
        wr(4'd8, 0);
        wr(4'd12, 0);
        collect("R10", 1);
        chk("R10", "zeroed count", wd[0], 0);
    endtask

    task automatic t_backpressure();
        logic [31:0] v;
        fresh(32'h0, ~32'h3);
        wr(4'd8, 0);
        out_ready = 1'b0;
        pulse(32'h3, 1);
        wr(4'd12, 0);
        chk("R11", "valid under stall", 32'(out_valid), 1);
        repeat (3) @(negedge clk);
        chk("R11", "data held", out_data, 1);
        chk("R11", "chan held", 32'(out_chan), 0);
        pulse(32'h1, 2);
        wr(4'd12, 0);
        wr(4'd12, 0);
        out_ready = 1'b1;
        collect("R12", 4);
        chk("R12", "w0", {wc[0][15:0], wd[0][15:0]}, {16'd0, 16'd1});
        chk("R12", "w1", {wc[1][15:0], wd[1][15:0]}, {16'd1, 16'd1});
        chk("R12", "held w2", {wc[2][15:0], wd[2][15:0]}, {16'd0, 16'd2});
        chk("R12", "held w3", {wc[3][15:0], wd[3][15:0]}, {16'd1, 16'd0});
        rd(4'd4, v);
        chk("R12", "merged advance count", v, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mask_order();
        t_accumulate();
        t_internal();
        t_step_ignored();
        t_external();
        t_preset();
        t_halt_clear();
        t_backpressure();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule